// File: doc/BRIEF.md
# Receive Ring Buffer Address Generator

This block generates the host memory write addresses for received packet data that is stored in a circular receive buffer. It is given the buffer base address, a 2-bit size code, a spill-mode bit and a stream of write requests, each carrying a byte count and a last-of-packet flag. For every accepted write it emits one or two address/length segments one cycle later. It also reports the buffer offset at which the next packet will begin.

The ring length is a power of two chosen by the size code, plus a fixed pad. When a write reaches the end of the ring in wrap mode, it is split in two. The first segment runs up to the end. The second segment starts again at the base. In spill mode, writes keep going linearly past the end of the ring. The next packet then starts at an offset equal to the number of bytes that spilled over. The largest ring size always wraps, whatever the spill bit says.

The bus transfers, the host read pointer and the buffer-full checks are handled outside this block. Each byte count must be smaller than the ring length. The bytes a packet spills past the end must also total less than the ring length.

Top module: `rx_ring_addr_gen`

## Requirements
- R1: After reset, or after a cycle with `init_i`=1, `pkt_start_o` is 0 and the next write is addressed at `base_addr_i`.
- R2: Size code c (0..3) selects a ring length L = 2^(RING_LOG2+c) + PAD bytes. The defaults give 8K, 16K, 32K and 64K, each plus 16.
- R3: A write of n bytes at offset o with o+n < L gives one segment. The segment is at `base_addr_i`+o with length n, and the offset advances by n.
- R4: In wrap mode (`spill_mode_i`=0), a write with o+n > L produces two segments in the same output cycle: segment 0 of L-o bytes at base+o, and segment 1 of o+n-L bytes at base.
- R5: A write ending exactly at L is not split, and the following offset is 0.
- R6: In spill mode (`spill_mode_i`=1, code below 3), a write crossing L is emitted whole at base+o. Later writes of the same packet continue at offsets beyond L.
- R7: In spill mode, after the last write of a packet ends at offset E ≥ L, the next packet starts at offset E-L.
- R8: With code 3, `spill_mode_i` is ignored and the block behaves as in wrap mode.
- R9: `seg0_valid_o` is 1 exactly in the cycle after a write is accepted (`wr_valid_i`=1, `init_i`=0). `seg1_valid_o` is 1 only together with it.
- R10: A write presented in the same cycle as `init_i`=1 is dropped: no segment follows it and the offsets become 0.
- R11: `pkt_start_o` changes only after a write with `wr_last_i`=1. It then equals that write's end offset reduced modulo L, and it is always below L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Re-initialise the ring offsets to 0 |
| base_addr_i | input | AW | Ring base address |
| len_code_i | input | 2 | Ring size code |
| spill_mode_i | input | 1 | 1 = spill past the end, 0 = wrap |
| wr_valid_i | input | 1 | Write request |
| wr_bytes_i | input | CW | Byte count of the write |
| wr_last_i | input | 1 | Write is the last one of a packet |
| seg0_valid_o | output | 1 | Segment 0 valid |
| seg0_addr_o | output | AW | Segment 0 address |
| seg0_len_o | output | CW | Segment 0 byte count |
| seg1_valid_o | output | 1 | Segment 1 (wrapped remainder) valid |
| seg1_addr_o | output | AW | Segment 1 address (ring base) |
| seg1_len_o | output | CW | Segment 1 byte count |
| pkt_start_o | output | OW | Start offset of the next packet |

## Verification
The bench uses a 16-byte base ring, so the lengths are 32, 48, 80 and 144. It sweeps all four size codes in both modes with a rolling pattern of byte counts and alternating packet ends. This compares every segment against an arithmetic model, and the compare separates wrap-splitting from spilling and code 3 from the others.

Directed sequences cover a write ending exactly at the ring end, a write crossing the end that is split in wrap mode, and a multi-write packet that spills with a carried start offset. They also cover a code 3 crossing with spill requested, which distinguishes an honoured spill bit from an ignored one.

An init arriving together with a write confirms the write is dropped. A gap between writes confirms the valid outputs fall back to 0.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {
    RING_X1 = 2'b00,
    RING_X2 = 2'b01,
    RING_X4 = 2'b10,
    RING_X8 = 2'b11
  } ring_code_e;
  localparam int unsigned NUM_CODES = 4;
endpackage

// File: rtl/rx_ring_size_dec.sv
module rx_ring_size_dec
  import rx_ring_pkg::*;
#(
  parameter int unsigned RING_LOG2 = 13,
  parameter int unsigned PAD       = 16,
  parameter int unsigned OW        = RING_LOG2 + 5
) (
  input  logic [1:0]    code_i,
  input  logic          spill_mode_i,
  output logic [OW-1:0] ring_len_o,
  output logic          spill_en_o
);
  logic [OW-1:0] len_tab [NUM_CODES];

  for (genvar g = 0; g < int'(NUM_CODES); g++) begin : g_len
    assign len_tab[g] = (OW'(1) << (RING_LOG2 + g)) + OW'(PAD);
  end

  assign ring_len_o = len_tab[code_i];
  // largest ring always wraps
  assign spill_en_o = spill_mode_i && (code_i != RING_X8);
endmodule

// File: rtl/rx_ring_seg_calc.sv
module rx_ring_seg_calc #(
  parameter int unsigned CW = 11,
  parameter int unsigned OW = 18
) (
  input  logic [OW-1:0] cur_off_i,
  input  logic [CW-1:0] bytes_i,
  input  logic [OW-1:0] ring_len_i,
  input  logic          spill_en_i,
  input  logic          last_i,
  output logic          split_o,
  output logic [CW-1:0] len0_o,
  output logic [CW-1:0] len1_o,
  output logic [OW-1:0] next_cur_o,
  output logic [OW-1:0] next_start_o
);
  logic [OW-1:0] end_off;
  logic [OW-1:0] wrapped;
  logic [OW-1:0] head;
  logic [OW-1:0] tail;

  always_comb begin
    end_off      = cur_off_i + OW'(bytes_i);
    split_o      = !spill_en_i && (end_off > ring_len_i);
    head         = ring_len_i - cur_off_i;
    tail         = end_off - ring_len_i;
    len0_o       = split_o ? CW'(head) : bytes_i;
    len1_o       = split_o ? CW'(tail) : '0;
    wrapped      = (end_off >= ring_len_i) ? tail : end_off;
    // mid-packet spill keeps the linear offset
    next_cur_o   = (spill_en_i && !last_i) ? end_off : wrapped;
    next_start_o = wrapped;
  end
endmodule

// File: rtl/rx_ring_offset_reg.sv
module rx_ring_offset_reg #(
  parameter int unsigned OW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          adv_i,
  input  logic          last_i,
  input  logic [OW-1:0] next_cur_i,
  input  logic [OW-1:0] next_start_i,
  input  logic [OW-1:0] ring_len_i,
  input  logic          spill_en_i,
  output logic [OW-1:0] cur_off_o,
  output logic [OW-1:0] pkt_start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_off_o   <= '0;
      pkt_start_o <= '0;
    end else if (init_i) begin
      cur_off_o   <= '0;
      pkt_start_o <= '0;
    end else if (adv_i) begin
      cur_off_o <= next_cur_i;
      if (last_i) pkt_start_o <= next_start_i;
    end
  end

  // R11
  start_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i |-> pkt_start_o < ring_len_i);

  // R4
  wrap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !spill_en_i) |-> cur_off_o < ring_len_i);

  // R11
  start_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adv_i && last_i) && !init_i |=> $stable(pkt_start_o));
endmodule

// File: rtl/rx_ring_addr_gen.sv
module rx_ring_addr_gen #(
  parameter int unsigned RING_LOG2 = 13,
  parameter int unsigned PAD       = 16,
  parameter int unsigned AW        = 32,
  parameter int unsigned CW        = 11,
  localparam int unsigned OW       = RING_LOG2 + 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [1:0]    len_code_i,
  input  logic          spill_mode_i,
  input  logic          wr_valid_i,
  input  logic [CW-1:0] wr_bytes_i,
  input  logic          wr_last_i,
  output logic          seg0_valid_o,
  output logic [AW-1:0] seg0_addr_o,
  output logic [CW-1:0] seg0_len_o,
  output logic          seg1_valid_o,
  output logic [AW-1:0] seg1_addr_o,
  output logic [CW-1:0] seg1_len_o,
  output logic [OW-1:0] pkt_start_o
);
  logic [OW-1:0] ring_len, cur_off, next_cur, next_start;
  logic          spill_en, split, adv;
  logic [CW-1:0] len0, len1;

  assign adv = wr_valid_i && !init_i;

  rx_ring_size_dec #(.RING_LOG2(RING_LOG2), .PAD(PAD), .OW(OW)) u_dec (
    .code_i      (len_code_i),
    .spill_mode_i(spill_mode_i),
    .ring_len_o  (ring_len),
    .spill_en_o  (spill_en)
  );

  rx_ring_seg_calc #(.CW(CW), .OW(OW)) u_calc (
    .cur_off_i   (cur_off),
    .bytes_i     (wr_bytes_i),
    .ring_len_i  (ring_len),
    .spill_en_i  (spill_en),
    .last_i      (wr_last_i),
    .split_o     (split),
    .len0_o      (len0),
    .len1_o      (len1),
    .next_cur_o  (next_cur),
    .next_start_o(next_start)
  );

  rx_ring_offset_reg #(.OW(OW)) u_off (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .adv_i       (adv),
    .last_i      (wr_last_i),
    .next_cur_i  (next_cur),
    .next_start_i(next_start),
    .ring_len_i  (ring_len),
    .spill_en_i  (spill_en),
    .cur_off_o   (cur_off),
    .pkt_start_o (pkt_start_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg0_valid_o <= 1'b0;
      seg0_addr_o  <= '0;
      seg0_len_o   <= '0;
      seg1_valid_o <= 1'b0;
      seg1_addr_o  <= '0;
      seg1_len_o   <= '0;
    end else begin
      seg0_valid_o <= adv;
      seg1_valid_o <= adv && split;
      if (adv) begin
        seg0_addr_o <= base_addr_i + AW'(cur_off);
        seg0_len_o  <= len0;
        seg1_addr_o <= base_addr_i;
        seg1_len_o  <= len1;
      end
    end
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg0_valid_o == $past(wr_valid_i && !init_i));

  // R9
  seg1_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg1_valid_o |-> seg0_valid_o);

  // R4
  seg_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg0_valid_o |-> ({1'b0, seg0_len_o} + (seg1_valid_o ? {1'b0, seg1_len_o} : '0))
                     == {1'b0, $past(wr_bytes_i)});

  // R4
  seg1_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg1_valid_o |-> seg1_addr_o == $past(base_addr_i));
endmodule

// File: tb/rx_ring_addr_gen_test.sv
module rx_ring_addr_gen_test;
  localparam int RL = 4, PD = 16, AW = 16, CW = 5, OW = RL + 5;

  logic clk = 0, rst_ni = 0, init_i = 0, spill_mode_i = 0;
  logic wr_valid_i = 0, wr_last_i = 0;
  logic [AW-1:0] base_addr_i = '0;
  logic [1:0] len_code_i = '0;
  logic [CW-1:0] wr_bytes_i = '0;
  logic seg0_valid_o, seg1_valid_o;
  logic [AW-1:0] seg0_addr_o, seg1_addr_o;
  logic [CW-1:0] seg0_len_o, seg1_len_o;
  logic [OW-1:0] pkt_start_o;

  int errors = 0, checks = 0;
  int m_cur = 0, m_start = 0, m_code = 0, m_mode = 0, m_base = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_ring_addr_gen #(.RING_LOG2(RL), .PAD(PD), .AW(AW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .base_addr_i(base_addr_i),
    .len_code_i(len_code_i), .spill_mode_i(spill_mode_i), .wr_valid_i(wr_valid_i),
    .wr_bytes_i(wr_bytes_i), .wr_last_i(wr_last_i), .seg0_valid_o(seg0_valid_o),
    .seg0_addr_o(seg0_addr_o), .seg0_len_o(seg0_len_o), .seg1_valid_o(seg1_valid_o),
    .seg1_addr_o(seg1_addr_o), .seg1_len_o(seg1_len_o), .pkt_start_o(pkt_start_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ring_len(input int code);
    return (1 << (RL + code)) + PD; // R2
  endfunction

  task automatic cfg(input int code, input int mode, input int base);
    len_code_i = 2'(code); spill_mode_i = mode[0]; base_addr_i = AW'(base);
    init_i = 1;
    @(posedge clk); @(negedge clk);
    init_i = 0;
    m_code = code; m_mode = mode; m_base = base; m_cur = 0; m_start = 0;
    chk("R1 start after init", int'(pkt_start_o), 0);
  endtask

  task automatic wr(input int n, input bit last);
    int L, e, l0, l1, wrapped;
    bit sp, split;
    L = ring_len(m_code);
    sp = (m_mode == 1) && (m_code != 3); // R8
    e = m_cur + n;
    split = !sp && (e > L);
    l0 = split ? L - m_cur : n;
    l1 = split ? e - L : 0;
    wrapped = (e >= L) ? e - L : e;
    wr_valid_i = 1; wr_bytes_i = CW'(n); wr_last_i = last;
    @(posedge clk); @(negedge clk);
    wr_valid_i = 0; wr_last_i = 0;
    chk("R9 seg0 valid", int'(seg0_valid_o), 1);
    chk("R3 seg0 addr", int'(seg0_addr_o), (m_base + m_cur) & 16'hFFFF);
    chk("R3 seg0 len", int'(seg0_len_o), l0);
    chk("R4 seg1 valid", int'(seg1_valid_o), int'(split));
    if (split) begin
      chk("R4 seg1 len", int'(seg1_len_o), l1);
      chk("R4 seg1 addr", int'(seg1_addr_o), m_base);
    end
    m_cur = (sp && !last) ? e : wrapped;
    if (last) m_start = wrapped;
    chk("R11 pkt start", int'(pkt_start_o), m_start);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset seg0 valid", int'(seg0_valid_o), 0);
    chk("R1 reset pkt start", int'(pkt_start_o), 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R9 idle no valid", int'(seg0_valid_o), 0);

    // directed wrap, code 0 (L=32)
    cfg(0, 0, 16'h1000);
    wr(16, 1);
    wr(16, 1);
    chk("R5 exact end not split", int'(seg1_valid_o), 0);
    chk("R5 exact end start 0", int'(pkt_start_o), 0);
    wr(20, 1);
    wr(20, 1);
    chk("R4 split head len", int'(seg0_len_o), 12);
    chk("R4 split tail len", int'(seg1_len_o), 8);
    chk("R4 split tail addr", int'(seg1_addr_o), 16'h1000);
    chk("R4 start after wrap", int'(pkt_start_o), 8);
    @(negedge clk);
    chk("R9 valid drops", int'(seg0_valid_o), 0);

    // directed spill, code 0
    cfg(0, 1, 16'h2000);
    wr(20, 0);
    wr(20, 0);
    chk("R6 whole write len", int'(seg0_len_o), 20);
    chk("R6 no split", int'(seg1_valid_o), 0);
    wr(4, 1);
    chk("R6 past end addr", int'(seg0_addr_o), 16'h2028);
    chk("R7 next start", int'(pkt_start_o), 12);
    wr(4, 1);
    chk("R7 next packet addr", int'(seg0_addr_o), 16'h200C);

    // R10: init with write
    init_i = 1; wr_valid_i = 1; wr_bytes_i = 5'd9;
    @(posedge clk); @(negedge clk);
    init_i = 0; wr_valid_i = 0;
    chk("R10 dropped seg0", int'(seg0_valid_o), 0);
    chk("R10 dropped seg1", int'(seg1_valid_o), 0);
    chk("R10 start cleared", int'(pkt_start_o), 0);
    m_cur = 0; m_start = 0;
    wr(3, 1);
    chk("R1 addr at base after init", int'(seg0_addr_o), 16'h2000);

    // R8: code 3 (L=144) with spill requested still wraps
    cfg(3, 1, 16'h3000);
    for (int i = 0; i < 5; i++) wr(30, 0);
    chk("R8 split len0", int'(seg0_len_o), 24);
    chk("R8 split len1", int'(seg1_len_o), 6);

    // sweep all codes and modes (R2 ring lengths)
    for (int code = 0; code < 4; code++)
      for (int mode = 0; mode < 2; mode++) begin
        cfg(code, mode, 16'h0100 * (code * 2 + mode + 1));
        for (int i = 0; i < 48; i++)
          wr(((i * 7 + code * 3 + mode) % 15) + 1, i[0]);
      end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule